// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit

This unit performs integer multiplication and division for a small 16/32-bit processor core. It works on register operands, one bit per clock. The core presents two operands and a three-bit operation code together with a start strobe. The unit then raises busy for a fixed number of cycles that depends only on the operand size. In the last of those cycles it pulses done, and at that point it presents either a product or a packed quotient/remainder pair, with zero, negative and divide-by-zero status.

Byte and word forms of both operations exist, and each one has a signed and an unsigned variant. One shift-and-add / shift-and-subtract datapath serves all eight forms. It works on operand magnitudes, and a final correction step restores the signs. Because the latency is fixed, a pipeline controller can schedule around the unit without looking at its handshake.

Top module: `mdu_top`

## Requirements
- R1: The operation code is decoded as follows: bit 2 selects the size (0 = byte, 1 = word), bit 1 selects divide (1) or multiply (0), and bit 0 selects signed (1) or unsigned (0) operands. When start is high and the unit is idle, the code and operands are captured, and busy is high in the next cycle.
- R2: A byte-size operation keeps busy high for exactly 14 consecutive cycles.
- R3: A word-size operation keeps busy high for exactly 22 consecutive cycles.
- R4: Done is high for exactly one cycle, which is the final busy cycle, and busy is low in the cycle after it.
- R5: A start request made while busy is high, including in the done cycle, has no effect on the operation in progress or on its timing.
- R6: A byte multiply places the 16-bit product of opa[7:0] and opb[7:0] in result[15:0], using two's complement when signed, and result[31:16] reads zero.
- R7: A word multiply places the 32-bit product of opa[15:0] and opb[15:0] in result[31:0], using two's complement when signed.
- R8: A byte divide takes the dividend from opa[15:0] and the divisor from opb[7:0]. The quotient goes to result[7:0], the remainder to result[15:8], and result[31:16] reads zero.
- R9: A word divide takes the dividend from opa[31:0] and the divisor from opb[15:0]. The quotient goes to result[15:0] and the remainder to result[31:16].
- R10: A signed divide truncates the quotient toward zero, and the remainder carries the sign of the dividend. When the quotient does not fit the quotient field, the result is unspecified.
- R11: A divide with a zero divisor finishes with the normal latency, and divzero is high from its done cycle onward. Every other operation clears divzero. The result and flags of a zero-divisor divide are unspecified.
- R12: In the done cycle, zero is high when the product (or quotient) at the operation's width is zero, and neg equals the top bit of that field.
- R13: After reset, busy, done, result and all status bits read zero. While the unit is idle, result holds the value delivered by the last completed operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new operation |
| op_i | input | 3 | Operation code {size, divide, signed} |
| opa_i | input | 32 | Multiplicand or dividend |
| opb_i | input | 16 | Multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse in the final busy cycle |
| result_o | output | 32 | Product, or {remainder, quotient} |
| zero_o | output | 1 | Product or quotient is zero |
| neg_o | output | 1 | Product or quotient sign bit |
| divzero_o | output | 1 | Last divide had a zero divisor |

## Verification
The assertions treat start as a request that may arrive in any cycle, including while busy. They also assume that the operation code captured at the accepting edge fixes the latency of the whole operation. The bench therefore holds start high through busy periods and feeds changing junk operands during them, so the ignore rule is tested under traffic. Quotient overflow is left unspecified, so random divide operands are drawn again until the quotient fits its signed or unsigned field. Zero divisors are then added on purpose, and for those operations only the timing and the divzero bit are compared.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int ACC_W  = 2 * WORD_W;
    localparam int CNT_W  = 5;

    typedef struct packed {
        logic word;
        logic div;
        logic sgn;
    } op_t;

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  step;
        op_t               op;
        logic              neg_q;
        logic              neg_r;
        logic              dz_p;
        logic [ACC_W-1:0]  acc;
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] mcand;
        logic [ACC_W-1:0]  res;
        logic              zf;
        logic              nf;
        logic              dz;
    } state_t;

endpackage

// File: rtl/mdu_prep.sv
module mdu_prep
    import mdu_pkg::*;
(
    input  op_t               op_i,
    input  logic [ACC_W-1:0]  opa_i,
    input  logic [WORD_W-1:0] opb_i,
    output logic [ACC_W-1:0]  acc_o,
    output logic [WORD_W-1:0] sh_o,
    output logic [WORD_W-1:0] mcand_o,
    output logic              neg_q_o,
    output logic              neg_r_o,
    output logic              dz_o
);
    logic [BYTE_W-1:0] a8, b8, ma8, mb8;
    logic [WORD_W-1:0] a16, b16, ma16, mb16;
    logic [ACC_W-1:0]  a32, ma32;
    logic              sa, sb;

    always_comb begin
        a8   = opa_i[BYTE_W-1:0];
        b8   = opb_i[BYTE_W-1:0];
        a16  = opa_i[WORD_W-1:0];
        b16  = opb_i;
        a32  = opa_i;
        sa   = 1'b0;
        sb   = 1'b0;
        ma8  = '0;
        mb8  = '0;
        ma16 = '0;
        mb16 = '0;
        ma32 = '0;
        acc_o   = '0;
        sh_o    = '0;
        mcand_o = '0;
        neg_r_o = 1'b0;
        dz_o    = 1'b0;
        case ({op_i.word, op_i.div})
            2'b00: begin
                sa  = op_i.sgn & a8[BYTE_W-1];
                sb  = op_i.sgn & b8[BYTE_W-1];
                ma8 = sa ? (~a8 + 1'b1) : a8;
                mb8 = sb ? (~b8 + 1'b1) : b8;
                mcand_o = {{(WORD_W-BYTE_W){1'b0}}, ma8};
                sh_o    = {mb8, {(WORD_W-BYTE_W){1'b0}}};
            end
            2'b01: begin
                sa   = op_i.sgn & a16[WORD_W-1];
                sb   = op_i.sgn & b8[BYTE_W-1];
                ma16 = sa ? (~a16 + 1'b1) : a16;
                mb8  = sb ? (~b8 + 1'b1) : b8;
                mcand_o = {{(WORD_W-BYTE_W){1'b0}}, mb8};
                acc_o   = {{(ACC_W-BYTE_W){1'b0}}, ma16[WORD_W-1:BYTE_W]};
                sh_o    = {ma16[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b0}}};
                neg_r_o = sa;
                dz_o    = (b8 == '0);
            end
            2'b10: begin
                sa   = op_i.sgn & a16[WORD_W-1];
                sb   = op_i.sgn & b16[WORD_W-1];
                ma16 = sa ? (~a16 + 1'b1) : a16;
                mb16 = sb ? (~b16 + 1'b1) : b16;
                mcand_o = ma16;
                sh_o    = mb16;
            end
            default: begin
                sa   = op_i.sgn & a32[ACC_W-1];
                sb   = op_i.sgn & b16[WORD_W-1];
                ma32 = sa ? (~a32 + 1'b1) : a32;
                mb16 = sb ? (~b16 + 1'b1) : b16;
                mcand_o = mb16;
                acc_o   = {{(ACC_W-WORD_W){1'b0}}, ma32[ACC_W-1:WORD_W]};
                sh_o    = ma32[WORD_W-1:0];
                neg_r_o = sa;
                dz_o    = (b16 == '0);
            end
        endcase
        neg_q_o = sa ^ sb;
    end
endmodule

// File: rtl/mdu_step.sv
module mdu_step
    import mdu_pkg::*;
(
    input  logic              div_i,
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [WORD_W-1:0] sh_i,
    input  logic [WORD_W-1:0] mcand_i,
    output logic [ACC_W-1:0]  acc_o,
    output logic [WORD_W-1:0] sh_o
);
    logic [WORD_W:0] trial;
    logic            fits;

    always_comb begin
        trial = {acc_i[WORD_W-1:0], sh_i[WORD_W-1]};
        fits  = trial >= {1'b0, mcand_i};
        if (div_i) begin
            acc_o = {{(ACC_W-WORD_W-1){1'b0}},
                     fits ? (trial - {1'b0, mcand_i}) : trial};
            sh_o  = {sh_i[WORD_W-2:0], fits};
        end else begin
            acc_o = (acc_i << 1)
                  + (sh_i[WORD_W-1] ? {{(ACC_W-WORD_W){1'b0}}, mcand_i} : '0);
            sh_o  = {sh_i[WORD_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/mdu_fixup.sv
module mdu_fixup
    import mdu_pkg::*;
(
    input  op_t               op_i,
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [WORD_W-1:0] sh_i,
    input  logic              neg_q_i,
    input  logic              neg_r_i,
    output logic [ACC_W-1:0]  res_o,
    output logic              zf_o,
    output logic              nf_o
);
    logic [WORD_W-1:0] p16, q16, r16;
    logic [ACC_W-1:0]  p32;
    logic [BYTE_W-1:0] q8, r8;

    always_comb begin
        p16 = acc_i[WORD_W-1:0];
        p32 = acc_i;
        q8  = sh_i[BYTE_W-1:0];
        r8  = acc_i[BYTE_W-1:0];
        q16 = sh_i;
        r16 = acc_i[WORD_W-1:0];
        if (neg_q_i) begin
            p16 = ~p16 + 1'b1;
            p32 = ~p32 + 1'b1;
            q8  = ~q8 + 1'b1;
            q16 = ~q16 + 1'b1;
        end
        if (neg_r_i) begin
            r8  = ~r8 + 1'b1;
            r16 = ~r16 + 1'b1;
        end
        case ({op_i.word, op_i.div})
            2'b00: begin
                res_o = {{(ACC_W-WORD_W){1'b0}}, p16};
                zf_o  = (p16 == '0);
                nf_o  = p16[WORD_W-1];
            end
            2'b01: begin
                res_o = {{(ACC_W-WORD_W){1'b0}}, r8, q8};
                zf_o  = (q8 == '0);
                nf_o  = q8[BYTE_W-1];
            end
            2'b10: begin
                res_o = p32;
                zf_o  = (p32 == '0);
                nf_o  = p32[ACC_W-1];
            end
            default: begin
                res_o = {r16, q16};
                zf_o  = (q16 == '0);
                nf_o  = q16[WORD_W-1];
            end
        endcase
    end
endmodule

// File: rtl/mdu_top.sv
module mdu_top
    import mdu_pkg::*;
#(
    parameter int LAT_BYTE = 14,
    parameter int LAT_WORD = 22
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic [ACC_W-1:0]  opa_i,
    input  logic [WORD_W-1:0] opb_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ACC_W-1:0]  result_o,
    output logic              zero_o,
    output logic              neg_o,
    output logic              divzero_o
);
    localparam logic [CNT_W-1:0] LAT_B_M1 = CNT_W'(LAT_BYTE - 1);
    localparam logic [CNT_W-1:0] LAT_W_M1 = CNT_W'(LAT_WORD - 1);
    localparam logic [CNT_W-1:0] STEPS_B  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] STEPS_W  = CNT_W'(WORD_W);

    state_t            q, d;
    op_t               op_in;
    logic [CNT_W-1:0]  steps_now;

    logic [ACC_W-1:0]  prep_acc, step_acc, fix_res;
    logic [WORD_W-1:0] prep_sh, prep_mcand, step_sh;
    logic              prep_nq, prep_nr, prep_dz, fix_zf, fix_nf;

    assign op_in     = op_t'(op_i);
    assign steps_now = q.op.word ? STEPS_W : STEPS_B;

    mdu_prep u_prep (
        .op_i    (op_in),
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .acc_o   (prep_acc),
        .sh_o    (prep_sh),
        .mcand_o (prep_mcand),
        .neg_q_o (prep_nq),
        .neg_r_o (prep_nr),
        .dz_o    (prep_dz)
    );

    mdu_step u_step (
        .div_i   (q.op.div),
        .acc_i   (q.acc),
        .sh_i    (q.sh),
        .mcand_i (q.mcand),
        .acc_o   (step_acc),
        .sh_o    (step_sh)
    );

    mdu_fixup u_fix (
        .op_i    (q.op),
        .acc_i   (q.acc),
        .sh_i    (q.sh),
        .neg_q_i (q.neg_q),
        .neg_r_i (q.neg_r),
        .res_o   (fix_res),
        .zf_o    (fix_zf),
        .nf_o    (fix_nf)
    );

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (start_i) begin
                d.busy  = 1'b1;
                d.cnt   = op_in.word ? LAT_W_M1 : LAT_B_M1;
                d.step  = '0;
                d.op    = op_in;
                d.acc   = prep_acc;
                d.sh    = prep_sh;
                d.mcand = prep_mcand;
                d.neg_q = prep_nq;
                d.neg_r = prep_nr;
                d.dz_p  = prep_dz;
            end
        end else begin
            if (q.cnt == '0) begin
                d.busy = 1'b0;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
            if (q.step < steps_now) begin
                d.acc  = step_acc;
                d.sh   = step_sh;
                d.step = q.step + 1'b1;
            end else if (q.step == steps_now) begin
                d.res  = fix_res;
                d.zf   = fix_zf;
                d.nf   = fix_nf;
                d.dz   = q.dz_p;
                d.step = q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o    = q.busy;
    assign done_o    = q.busy && (q.cnt == '0);
    assign result_o  = q.res;
    assign zero_o    = q.zf;
    assign neg_o     = q.nf;
    assign divzero_o = q.dz;
endmodule

// File: rtl/mdu_chk.sv
module mdu_chk #(
    parameter int LAT_BYTE = 14,
    parameter int LAT_WORD = 22
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        start_i,
    input logic        op_word_i,
    input logic        op_div_i,
    input logic        busy_o,
    input logic        done_o,
    input logic [31:0] result_o,
    input logic        zero_o,
    input logic        neg_o,
    input logic        divzero_o
);
    logic [7:0] run_cnt;
    logic       word_q;
    logic       div_q;
    logic [7:0] lat_now;

    assign lat_now = word_q ? 8'(LAT_WORD) : 8'(LAT_BYTE);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_cnt <= '0;
            word_q  <= 1'b0;
            div_q   <= 1'b0;
        end else if (!busy_o && start_i) begin
            run_cnt <= 8'd1;
            word_q  <= op_word_i;
            div_q   <= op_div_i;
        end else if (busy_o) begin
            run_cnt <= run_cnt + 8'd1;
        end
    end

    // R1
    accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i) |=> busy_o);

    // R2
    latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (run_cnt == lat_now));

    // R3
    no_early_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !done_o) |-> (run_cnt < lat_now));

    // R4
    done_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> busy_o);

    // R4
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (!done_o && !busy_o));

    // R5
    busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !done_o) |=> busy_o);

    // R11
    dz_mul_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !div_q) |-> !divzero_o);

    // R13
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !start_i) |=> ($stable(result_o) && $stable(zero_o)
                                   && $stable(neg_o) && $stable(divzero_o)));
endmodule

bind mdu_top mdu_chk #(
    .LAT_BYTE (LAT_BYTE),
    .LAT_WORD (LAT_WORD)
) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .op_word_i (op_i[2]),
    .op_div_i  (op_i[1]),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .result_o  (result_o),
    .zero_o    (zero_o),
    .neg_o     (neg_o),
    .divzero_o (divzero_o)
);

// File: tb/mdu_top_tb_top.sv
module mdu_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LAT_B = 14;
    localparam int LAT_W = 22;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [31:0] opa_i = '0;
    logic [15:0] opb_i = '0;
    logic        busy_o, done_o, zero_o, neg_o, divzero_o;
    logic [31:0] result_o;

    int n_vec = 0;
    int n_bad = 0;

    bit          m_busy = 0;
    int          m_left = 0;
    int          m_lat = 0;
    logic [31:0] m_res = '0;
    bit          m_zf, m_nf, m_dz;
    logic [31:0] m_hold = '0;
    bit          m_hold_ok = 1;
    string       m_tlat = "R2";
    string       m_tres = "R6";

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    mdu_top #(.LAT_BYTE(LAT_B), .LAT_WORD(LAT_W)) dut_i (
        .clk_i, .rst_ni, .start_i, .op_i, .opa_i, .opb_i,
        .busy_o, .done_o, .result_o, .zero_o, .neg_o, .divzero_o
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic predict(input logic [2:0] op, input logic [31:0] a, input logic [15:0] b);
        longint x, y, p, qv, rv;
        bit wd, dv, sg;
        wd = op[2]; dv = op[1]; sg = op[0];
        m_dz = 0; m_res = '0; m_zf = 0; m_nf = 0;
        m_lat  = wd ? LAT_W : LAT_B;
        m_tlat = wd ? "R3" : "R2";
        if (!dv) begin
            m_tres = wd ? "R7" : "R6";
            if (!wd) begin
                x = sg ? longint'($signed(a[7:0])) : longint'(a[7:0]);
                y = sg ? longint'($signed(b[7:0])) : longint'(b[7:0]);
                p = x * y;
                m_res = {16'h0, p[15:0]};
                m_zf = (p[15:0] == 0); m_nf = p[15];
            end else begin
                x = sg ? longint'($signed(a[15:0])) : longint'(a[15:0]);
                y = sg ? longint'($signed(b)) : longint'(b);
                p = x * y;
                m_res = p[31:0];
                m_zf = (p[31:0] == 0); m_nf = p[31];
            end
        end else begin
            m_tres = sg ? "R10" : (wd ? "R9" : "R8");
            if (!wd) begin
                x = sg ? longint'($signed(a[15:0])) : longint'(a[15:0]);
                y = sg ? longint'($signed(b[7:0])) : longint'(b[7:0]);
            end else begin
                x = sg ? longint'($signed(a)) : longint'(a);
                y = sg ? longint'($signed(b)) : longint'(b);
            end
            if (y == 0) begin
                m_dz = 1;
            end else begin
                qv = x / y;
                rv = x % y;
                if (!wd) begin
                    m_res = {16'h0, rv[7:0], qv[7:0]};
                    m_zf = (qv[7:0] == 0); m_nf = qv[7];
                end else begin
                    m_res = {rv[15:0], qv[15:0]};
                    m_zf = (qv[15:0] == 0); m_nf = qv[15];
                end
            end
        end
    endtask

    // one clock: compare at negedge, then drive and advance the model
    task automatic cycle(input bit st, input logic [2:0] op,
                         input logic [31:0] a, input logic [15:0] b);
        string tb;
        tb = (m_busy && m_left == m_lat) ? "R1" : (st && m_busy) ? "R5" : m_tlat;
        check(tb, busy_o, m_busy);
        check("R4", done_o, m_busy && m_left == 1);
        if (m_busy && m_left == 1) begin
            check("R11", divzero_o, m_dz);
            if (!m_dz) begin
                check(m_tres, result_o, m_res);
                check("R12", zero_o, m_zf);
                check("R12", neg_o, m_nf);
            end
        end
        if (!m_busy && m_hold_ok) check("R13", result_o, m_hold);
        start_i = st; op_i = op; opa_i = a; opb_i = b;
        if (m_busy) begin
            m_left--;
            if (m_left == 0) begin
                m_busy = 0;
                m_hold = m_res;
                m_hold_ok = !m_dz;
            end
        end else if (st) begin
            predict(op, a, b);
            m_busy = 1;
            m_left = m_lat;
        end
        @(negedge clk_i);
    endtask

    task automatic run_op(input logic [2:0] op, input logic [31:0] a,
                          input logic [15:0] b, input bit junk);
        cycle(1'b1, op, a, b);
        while (m_busy) begin
            if (junk) cycle($urandom_range(0, 1) == 1, 3'($urandom), $urandom, 16'($urandom));
            else      cycle(1'b0, op, a, b);
        end
        cycle(1'b0, op, a, b);
    endtask

    task automatic gen_div(input logic [2:0] op, output logic [31:0] a, output logic [15:0] b);
        longint x, y, qv;
        bit ok;
        ok = 0;
        a = 32'd100; b = 16'd7;
        for (int k = 0; k < 200 && !ok; k++) begin
            logic [31:0] ra;
            logic [15:0] rb;
            ra = $urandom >> $urandom_range(0, 31);
            rb = 16'($urandom) >> $urandom_range(0, 15);
            if (!op[2]) begin
                ra = {16'h0, ra[15:0]}; rb = {8'h0, rb[7:0]};
                x = op[0] ? longint'($signed(ra[15:0])) : longint'(ra[15:0]);
                y = op[0] ? longint'($signed(rb[7:0])) : longint'(rb[7:0]);
            end else begin
                x = op[0] ? longint'($signed(ra)) : longint'(ra);
                y = op[0] ? longint'($signed(rb)) : longint'(rb);
            end
            if (y != 0) begin
                qv = x / y;
                if (op[0]) ok = op[2] ? (qv >= -32768 && qv <= 32767) : (qv >= -128 && qv <= 127);
                else       ok = op[2] ? (qv <= 65535) : (qv <= 255);
                if (ok) begin a = ra; b = rb; end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] ra;
        logic [15:0] rb;
        logic [2:0]  rop;
        repeat (3) @(negedge clk_i);
        // R13 reset state
        check("R13", busy_o, 0);
        check("R13", done_o, 0);
        check("R13", result_o, 0);
        check("R13", {zero_o, neg_o, divzero_o}, 0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        cycle(1'b0, 3'b000, 0, 0);
        // directed corners
        run_op(3'b000, 32'hFF, 16'hFF, 0);           // R6 unsigned max
        run_op(3'b001, 32'h80, 16'h80, 0);           // R6 signed -128*-128
        run_op(3'b001, 32'h80, 16'h01, 1);           // R6 negative product, R5 junk
        run_op(3'b000, 32'h00, 16'h5A, 0);           // R12 zero product
        run_op(3'b100, 32'hFFFF, 16'hFFFF, 0);       // R7 unsigned max
        run_op(3'b101, 32'h8000, 16'h8000, 1);       // R7 signed min*min
        run_op(3'b101, 32'h0003, 16'hFFFB, 0);       // R7 3 * -5
        run_op(3'b010, 32'd1000, 16'd7, 0);          // R8
        run_op(3'b011, 32'hFFF9, 16'h02, 0);         // R10 -7/2
        run_op(3'b011, 32'h0007, 16'hFE, 1);         // R10 7/-2
        run_op(3'b010, 32'd5, 16'd9, 0);             // R12 zero quotient
        run_op(3'b110, 32'h0012_3456, 16'h0100, 0);  // R9
        run_op(3'b111, 32'hFFFF_8000, 16'h0001, 0);  // R10 quotient -32768
        run_op(3'b010, 32'd77, 16'h00, 0);           // R11 byte zero divisor
        run_op(3'b111, 32'd77, 16'h0000, 1);         // R11 word zero divisor
        run_op(3'b000, 32'd3, 16'd4, 0);             // R11 cleared afterwards
        // random traffic
        for (int i = 0; i < 320; i++) begin
            rop = 3'($urandom);
            if (rop[1]) gen_div(rop, ra, rb);
            else begin ra = $urandom; rb = 16'($urandom); end
            if (($urandom % 16) == 0) rb = '0;
            run_op(rop, ra, rb, $urandom_range(0, 1) == 1);
            repeat ($urandom_range(0, 2)) cycle(1'b0, rop, ra, rb);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule